// File: doc/BRIEF.md
# Tag-Renaming Out-of-Order Issue Scheduler

This block is the dynamic scheduling core of a small floating-point style datapath. Instructions reach it one at a time from the head of an in-order operation queue. Each instruction names an operation, a destination register and two source registers. When a station of the right class is free, the instruction is placed in it. The destination register is then renamed to that station's tag. Each source is captured at that moment. A source that is already settled is captured as a value. A source that is still being computed is captured as the tag of the station that will produce it.

Stations watch one shared result bus. A station with both operands in hand counts down its unit's fixed latency and then asks for the bus. One result is granted per cycle. The winner's value and tag reach every waiting station and the register table together, and the winning station becomes free. Renaming of the destination means that write-after-read and write-after-write conflicts never hold back issue or result writing.

There are two station classes, an adder class and a multiplier class, over a small register file. The register file and its rename table are kept inside the block. A read port lets the surrounding pipeline and the bench observe both.

Top module: `rs_sched`

## Requirements
- R1: After reset, every station is free, every register's pending-writer tag reads 0, register i holds the value i, and the result bus is idle.
- R2: `iss_ready` is 1 exactly when a station of the class of `iss_op` is free. Op codes are 0 = add and 1 = subtract (adder class), 2 = multiply (multiplier class), and 3 is treated as add. An instruction is taken on a rising edge where `iss_valid` and `iss_ready` are both 1.
- R3: The result is src1+src2 for add, src1-src2 for subtract and the low DW bits of src1*src2 for multiply. The register contents after all instructions drain equal those of executing the instructions one after another in issue order.
- R4: An instruction whose operands are settled at issue drives the bus starting exactly ADD_LAT (adder class) or MUL_LAT (multiplier class) rising edges after its issue edge, provided it wins the bus.
- R5: At most one result is on the bus in a cycle, and the lowest tag among the requesters wins. A station that loses keeps its result and requests again in the next cycle.
- R6: Every station waiting on a tag captures the value in the cycle that tag is broadcast. Several stations may do so in the same cycle, and each then starts counting on the following edge.
- R7: A broadcast clears a register's pending-writer tag, and writes its value, only when the entry still names the broadcasting tag. A later issue to that register keeps its own tag.
- R8: When an instruction issues in the same cycle that its source's producer is on the bus, the new station takes the bus value directly and does not wait on the tag.
- R9: Tag 0 means "no producer". Adder stations carry tags 1..ADD_RS and multiplier stations carry the tags after them. Issue picks the lowest free tag of the class.
- R10: A station is freed on the edge that grants it the bus and can take a new instruction from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| iss_valid | input | 1 | Queue head holds an instruction |
| iss_op | input | 2 | Operation code (see R2) |
| iss_dst | input | AW | Destination register |
| iss_src1 | input | AW | First source register |
| iss_src2 | input | AW | Second source register |
| iss_ready | output | 1 | A station of the required class is free |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | TW | Tag of the broadcasting station |
| cdb_value | output | DW | Broadcast result |
| rd_addr | input | AW | Observation read address |
| rd_data | output | DW | Register value at rd_addr |
| rd_tag | output | TW | Pending-writer tag of rd_addr, 0 when settled |

## Verification
`iss_ready` is combinational and is sampled one nanosecond after the inputs change. A result whose operands were settled at issue is on the bus ADD_LAT or MUL_LAT edges after the issue edge. A dependent result follows its producer's grant edge by the same latency, so its bus cycle sits LAT+1 cycles after the producer's bus cycle. The register table changes on the grant edge, one cycle after the value is shown on the bus. The bench counts edges from each issue and samples between edges at exactly those cycles. It logs every bus cycle with its cycle number to check ordering and spacing. After a long random stream it lets the design drain and compares every register with an in-order model.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_RSV = 2'd3
  } op_e;
endpackage

// File: rtl/rs_arb.sv
// Fixed-priority one-hot grant: the lowest index (lowest tag) wins.
module rs_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/rs_regfile.sv
// Register values plus pending-writer table, with three combinational read ports.
module rs_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_we,
  input  logic [AW-1:0] ren_dst,
  input  logic [TW-1:0] ren_tag,
  input  logic          bus_valid,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_val,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [DW-1:0] rv1,
  output logic [DW-1:0] rv2,
  output logic [DW-1:0] rv3,
  output logic [TW-1:0] rq1,
  output logic [TW-1:0] rq2,
  output logic [TW-1:0] rq3
);
  logic [DW-1:0] val_q [NREG];
  logic [DW-1:0] val_n [NREG];
  logic [TW-1:0] own_q [NREG];
  logic [TW-1:0] own_n [NREG];

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      val_n[r] = val_q[r];
      own_n[r] = own_q[r];
      // a result lands only if this register still waits on that very tag
      if (bus_valid && own_q[r] == bus_tag) begin
        val_n[r] = bus_val;
        own_n[r] = '0;
      end
      // a rename in the same cycle overrides the clear
      if (ren_we && ren_dst == AW'(r)) own_n[r] = ren_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        val_q[r] <= DW'(r);
        own_q[r] <= '0;
      end
    end else if (ren_we || bus_valid) begin
      for (int r = 0; r < NREG; r++) begin
        val_q[r] <= val_n[r];
        own_q[r] <= own_n[r];
      end
    end
  end

  assign rv1 = val_q[ra1];
  assign rv2 = val_q[ra2];
  assign rv3 = val_q[ra3];
  assign rq1 = own_q[ra1];
  assign rq2 = own_q[ra2];
  assign rq3 = own_q[ra3];
endmodule

// File: rtl/rs_station.sv
// One reservation station with its own fixed-latency execution stub.
module rs_station import rs_pkg::*; #(
  parameter int DW  = 16,
  parameter int TW  = 3,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  op_e           a_op,
  input  logic [DW-1:0] a_vj,
  input  logic [TW-1:0] a_qj,
  input  logic [DW-1:0] a_vk,
  input  logic [TW-1:0] a_qk,
  input  logic          bus_valid,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_val,
  input  logic          grant,
  output logic          busy,
  output logic          req,
  output logic [DW-1:0] res
);
  localparam int CW = $clog2(LAT + 1);

  logic          busy_q, busy_n, done_q, done_n;
  op_e           op_q, op_n;
  logic [DW-1:0] vj_q, vj_n, vk_q, vk_n;
  logic [TW-1:0] qj_q, qj_n, qk_q, qk_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          en;

  always_comb begin
    busy_n = busy_q; done_n = done_q; op_n = op_q;
    vj_n = vj_q; vk_n = vk_q; qj_n = qj_q; qk_n = qk_q; cnt_n = cnt_q;
    if (alloc) begin
      busy_n = 1'b1; done_n = 1'b0; op_n = a_op;
      vj_n = a_vj; qj_n = a_qj; vk_n = a_vk; qk_n = a_qk;
      cnt_n = CW'(LAT);
    end else if (grant) begin
      busy_n = 1'b0;
      done_n = 1'b0;
    end else if (busy_q) begin
      if (qj_q == '0 && qk_q == '0 && !done_q) begin
        cnt_n = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) done_n = 1'b1;
      end
      if (qj_q != '0 && bus_valid && bus_tag == qj_q) begin
        vj_n = bus_val; qj_n = '0;
      end
      if (qk_q != '0 && bus_valid && bus_tag == qk_q) begin
        vk_n = bus_val; qk_n = '0;
      end
    end
  end

  assign en = alloc | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; op_q <= OP_ADD;
      vj_q <= '0; vk_q <= '0; qj_q <= '0; qk_q <= '0; cnt_q <= '0;
    end else if (en) begin
      busy_q <= busy_n; done_q <= done_n; op_q <= op_n;
      vj_q <= vj_n; vk_q <= vk_n; qj_q <= qj_n; qk_q <= qk_n; cnt_q <= cnt_n;
    end
  end

  always_comb begin
    case (op_q)
      OP_SUB:  res = vj_q - vk_q;
      OP_MUL:  res = vj_q * vk_q;
      default: res = vj_q + vk_q;
    endcase
  end

  assign busy = busy_q;
  assign req  = busy_q & done_q;
endmodule

// File: rtl/rs_sched.sv
module rs_sched import rs_pkg::*; #(
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int ADD_RS  = 3,
  parameter int MUL_RS  = 2,
  parameter int ADD_LAT = 2,
  parameter int MUL_LAT = 4,
  parameter int NRS     = ADD_RS + MUL_RS,
  parameter int TW      = $clog2(NRS + 1),
  parameter int AW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_op,
  input  logic [AW-1:0] iss_dst,
  input  logic [AW-1:0] iss_src1,
  input  logic [AW-1:0] iss_src2,
  output logic          iss_ready,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [DW-1:0] cdb_value,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [TW-1:0] rd_tag
);
  logic [NRS-1:0] st_busy, st_req, st_gnt, st_alloc;
  logic [DW-1:0]  st_res [NRS];
  logic [DW-1:0]  rv1, rv2, vj, vk;
  logic [TW-1:0]  rq1, rq2, qj, qk, pick_tag;
  logic           is_mul, found, fire;
  op_e            op_in;

  assign op_in  = op_e'(iss_op);
  assign is_mul = (op_in == OP_MUL);

  // lowest free station of the required class
  always_comb begin
    found    = 1'b0;
    pick_tag = '0;
    for (int i = NRS - 1; i >= 0; i--) begin
      if (!st_busy[i] && ((i >= ADD_RS) == is_mul)) begin
        found    = 1'b1;
        pick_tag = TW'(i + 1);
      end
    end
  end

  assign iss_ready = found;
  assign fire      = iss_valid & found;

  always_comb begin
    for (int i = 0; i < NRS; i++) st_alloc[i] = fire && (pick_tag == TW'(i + 1));
  end

  // source capture: settled value, same-cycle bus value, or producer tag
  always_comb begin
    vj = rv1; qj = '0;
    if (rq1 != '0) begin
      if (cdb_valid && cdb_tag == rq1) vj = cdb_value;
      else begin vj = '0; qj = rq1; end
    end
    vk = rv2; qk = '0;
    if (rq2 != '0) begin
      if (cdb_valid && cdb_tag == rq2) vk = cdb_value;
      else begin vk = '0; qk = rq2; end
    end
  end

  rs_arb #(.N(NRS)) u_arb (.req(st_req), .gnt(st_gnt));

  always_comb begin
    cdb_valid = |st_gnt;
    cdb_tag   = '0;
    cdb_value = '0;
    for (int i = 0; i < NRS; i++) begin
      if (st_gnt[i]) begin
        cdb_tag   = TW'(i + 1);
        cdb_value = st_res[i];
      end
    end
  end

  for (genvar g = 0; g < NRS; g++) begin : g_st
    localparam int LAT = (g < ADD_RS) ? ADD_LAT : MUL_LAT;
    rs_station #(.DW(DW), .TW(TW), .LAT(LAT)) u_st (
      .clk(clk), .rst_n(rst_n), .alloc(st_alloc[g]), .a_op(op_in),
      .a_vj(vj), .a_qj(qj), .a_vk(vk), .a_qk(qk),
      .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_val(cdb_value),
      .grant(st_gnt[g]), .busy(st_busy[g]), .req(st_req[g]), .res(st_res[g])
    );
  end

  rs_regfile #(.NREG(NREG), .DW(DW), .TW(TW), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ren_we(fire), .ren_dst(iss_dst), .ren_tag(pick_tag),
    .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_val(cdb_value),
    .ra1(iss_src1), .ra2(iss_src2), .ra3(rd_addr),
    .rv1(rv1), .rv2(rv2), .rv3(rd_data),
    .rq1(rq1), .rq2(rq2), .rq3(rd_tag)
  );
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int NRS = 5,
  parameter int TW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cdb_valid,
  input logic [TW-1:0]  cdb_tag,
  input logic [NRS-1:0] busy_vec,
  input logic [NRS-1:0] req_vec,
  input logic [NRS-1:0] gnt_vec
);
  a_r9_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (cdb_tag != '0 && cdb_tag <= TW'(NRS)));

  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> ((req_vec & (gnt_vec - NRS'(1))) == '0));

  a_r5_loser_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_vec & ~gnt_vec) != '0) |=> (($past(req_vec) & ~$past(gnt_vec) & ~req_vec) == '0));

  a_r10_freed_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |=> (($past(gnt_vec) & busy_vec) == '0));

  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_vec == '0) |-> !cdb_valid);

  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec) && (cdb_valid == (gnt_vec != '0)));
endmodule

bind rs_sched rs_sched_chk #(.NRS(NRS), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
  .busy_vec(st_busy), .req_vec(st_req), .gnt_vec(st_gnt)
);

// File: tb/rs_sched_test.sv
`timescale 1ns/1ps
module rs_sched_test;
  localparam int NREG = 8, DW = 16, ADD_RS = 3, MUL_RS = 2, ADD_LAT = 2, MUL_LAT = 4;
  localparam int TW = 3, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [1:0] iss_op = '0;
  logic [AW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0, rd_addr = '0;
  logic iss_ready, cdb_valid;
  logic [TW-1:0] cdb_tag, rd_tag;
  logic [DW-1:0] cdb_value, rd_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;
  logic [DW-1:0] mreg [NREG];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rs_sched #(.NREG(NREG), .DW(DW), .ADD_RS(ADD_RS), .MUL_RS(MUL_RS),
             .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
    .iss_ready(iss_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_value(cdb_value), .rd_addr(rd_addr), .rd_data(rd_data), .rd_tag(rd_tag));

  function automatic logic [DW-1:0] alu(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] r;
    case (op)
      1: r = a - b;
      2: r = a * b;
      default: r = a + b;
    endcase
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic issue(input int op, input int d, input int s1, input int s2);
    @(negedge clk);
    iss_op = 2'(op); iss_dst = AW'(d); iss_src1 = AW'(s1); iss_src2 = AW'(s2);
    iss_valid = 1'b1;
    #1;
    while (!iss_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    iss_valid = 1'b0;
    mreg[d] = alu(op, mreg[s1], mreg[s2]);
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk); rd_addr = AW'(r); #1;
      chk(rd_data == mreg[r], req, rd_data, mreg[r]);
      chk(rd_tag == '0, req, rd_tag, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int ltag [8];
    int lcyc [8];
    int n;
    void'($urandom(32'd4242));
    for (int r = 0; r < NREG; r++) mreg[r] = DW'(r);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    @(negedge clk); #1;
    chk(cdb_valid == 1'b0, "R1 bus idle", cdb_valid, 0);
    chk(iss_ready == 1'b1, "R1 stations free", iss_ready, 1);
    check_regs("R1 reset regs");

    // R4/R3/R9: add latency, value and first adder tag
    issue(0, 1, 2, 3);
    repeat (ADD_LAT - 1) @(posedge clk);
    #1 chk(cdb_valid == 1'b0, "R4 add not early", cdb_valid, 0);
    @(posedge clk); #1;
    chk(cdb_valid == 1'b1, "R4 add on time", cdb_valid, 1);
    chk(cdb_tag == 3'd1, "R9 add tag", cdb_tag, 1);
    chk(cdb_value == 16'd5, "R3 add value", cdb_value, 5);

    // R4/R3/R9: multiply latency, value and first multiplier tag
    issue(2, 4, 2, 3);
    repeat (MUL_LAT - 1) @(posedge clk);
    #1 chk(cdb_valid == 1'b0, "R4 mul not early", cdb_valid, 0);
    @(posedge clk); #1;
    chk(cdb_valid == 1'b1, "R4 mul on time", cdb_valid, 1);
    chk(cdb_tag == TW'(ADD_RS + 1), "R9 mul tag", cdb_tag, ADD_RS + 1);
    chk(cdb_value == 16'd6, "R3 mul value", cdb_value, 6);
    repeat (8) @(posedge clk);
    check_regs("R3 directed regs");

    // R2/R5/R6/R7: three adders wait on one multiply, all write r5
    rd_addr = 3'd5;
    issue(2, 7, 2, 2);
    issue(0, 5, 7, 1);
    issue(0, 5, 7, 2);
    issue(0, 5, 7, 3);
    iss_op = 2'd0; #1;
    chk(iss_ready == 1'b0, "R2 adders full", iss_ready, 0);
    iss_op = 2'd2; #1;
    chk(iss_ready == 1'b1, "R2 multiplier free", iss_ready, 1);
    n = 0;
    for (int w = 0; w < 40 && n < 4; w++) begin
      @(negedge clk); #1;
      if (cdb_valid) begin
        ltag[n] = int'(cdb_tag); lcyc[n] = cyc;
        if (cdb_tag == 3'd3) chk(rd_tag == 3'd3, "R7 later writer kept", rd_tag, 3);
        n++;
      end
    end
    chk(n == 4, "R5 broadcast count", n, 4);
    chk(ltag[0] == ADD_RS + 1, "R6 producer first", ltag[0], ADD_RS + 1);
    chk(ltag[1] == 1 && lcyc[1] - lcyc[0] == ADD_LAT + 1, "R6 joint capture", lcyc[1] - lcyc[0], ADD_LAT + 1);
    chk(ltag[2] == 2 && lcyc[2] - lcyc[1] == 1, "R5 second retries", ltag[2], 2);
    chk(ltag[3] == 3 && lcyc[3] - lcyc[2] == 1, "R5 third retries", ltag[3], 3);
    @(negedge clk); #1;
    chk(rd_tag == '0, "R7 cleared by own tag", rd_tag, 0);
    chk(rd_data == mreg[5], "R7 last write wins", rd_data, mreg[5]);

    // R8: consumer issues in the cycle its producer is on the bus
    repeat (6) @(posedge clk);
    issue(0, 6, 2, 3);
    @(posedge clk); @(posedge clk);
    issue(0, 0, 6, 6);
    repeat (ADD_LAT - 1) @(posedge clk);
    @(posedge clk); #1;
    chk(cdb_valid == 1'b1 && cdb_tag == 3'd2, "R8 consumer on time", cdb_tag, 2);
    chk(cdb_value == 16'd10, "R8 bus value captured", cdb_value, 10);
    repeat (6) @(posedge clk);
    check_regs("R8 regs");

    // R3/R10: random stream against in-order model
    for (int k = 0; k < 400; k++) begin
      issue(int'($urandom_range(0, 2)), int'($urandom_range(0, NREG - 1)),
            int'($urandom_range(0, NREG - 1)), int'($urandom_range(0, NREG - 1)));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(posedge clk);
    end
    repeat (60) @(posedge clk);
    check_regs("R3 R10 random regs");
    finish_run();
  end
endmodule